// File: doc/BRIEF.md
# Protection Key Permission Checker

This block decides whether a memory access may go ahead. Each translated page entry carries a small protection key. The block uses that key to index a per-thread permission register, which holds an access-disable bit and a write-disable bit for every key. The block combines the key bits with the access type and with the outcome of the ordinary page permission check. It returns a decision in the same cycle, and it also gives a registered copy of that decision one cycle later. Because the permission register is separate from the page tables, software can change the rights of a whole protection domain with one register write and without editing any page entry.

Software reads and writes the permission register through a plain register port. The register holds the state of the thread that is running now. Saving and restoring it on a thread switch is left to the surrounding logic. Key checks apply only to data accesses. When an access faults, a cause code tells a key violation apart from an ordinary page violation.

A parameter selects between two sizes. The default uses a 4-bit key with 16 keys and a 32-bit register. The wide size uses a 5-bit key with 32 keys and a 64-bit register.

Top module: `pkey_checker`

## Requirements
- R1: After reset the permission register reads as all zeros, `rsp_valid` is 0, and every key permits loads and stores.
- R2: Key k uses register bit 2k as its access-disable bit and bit 2k+1 as its write-disable bit. A value written through the software port reads back unchanged.
- R3: A load (`req_type` 0) whose page check passes faults with the key cause exactly when the key's access-disable bit is set. The write-disable bit alone never blocks a load.
- R4: A store (`req_type` 1) whose page check passes faults with the key cause when either the access-disable bit or the write-disable bit of its key is set.
- R5: An instruction fetch (`req_type` 2) never gets the key cause, whatever the key bits hold.
- R6: When `req_page_ok` is 0, a valid request gets the page cause for every access type. The page cause takes priority over the key cause.
- R7: The cause encoding is 0 for none, 1 for page and 2 for key. `chk_allow` is 1 exactly when the cause is none.
- R8: A register write takes effect for requests from the cycle after the write. A request in the same cycle as the write is judged against the old value.
- R9: `rsp_valid`, `rsp_fault` and `rsp_cause` repeat, one clock later, the request valid bit, the inverted allow bit and the cause. When no request was valid in that cycle, `rsp_valid` is 0 and `rsp_cause` is 0.
- R10: The reserved access type 3 is checked like a store.
- R11: With `WIDE_KEYS` set to 1, the key is 5 bits wide, there are 32 keys, and the register is 64 bits wide. Key 31 uses bits 62 and 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_wr_en | input | 1 | Software write strobe for the permission register |
| sw_wr_data | input | REG_W (32) | Value to write into the permission register |
| sw_rd_data | output | REG_W (32) | Current value of the permission register |
| req_valid | input | 1 | An access request is present |
| req_key | input | KEY_W (4) | Protection key taken from the translated page entry |
| req_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved (checked as a store) |
| req_page_ok | input | 1 | The ordinary page permission check passed |
| chk_allow | output | 1 | Same-cycle decision: 1 means the access may proceed |
| chk_cause | output | 2 | Same-cycle cause: 0 none, 1 page, 2 key |
| rsp_valid | output | 1 | Registered copy of the request valid bit |
| rsp_fault | output | 1 | Registered fault flag |
| rsp_cause | output | 2 | Registered cause code |

## Verification
The bench sets the two permission bits of a key one at a time. This catches a design that treats write-disable as blocking loads, or one that lets access-disable alone pass a store. It puts a page denial on top of set key bits, and it uses fetches with all bits set. A design with the wrong priority would report the key cause in those cases, and a design that checks fetches would fault them. Keys 0 and 15 are used to expose a shifted bit layout at the ends of the register. A request issued in the same cycle as a write shows whether the new bits leak in a cycle early. The wide instance is driven on key 31 to catch a key index or register width that is stuck at the default size.

// File: rtl/pkey_pkg.sv
package pkey_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_PAGE = 2'd1,
        CAUSE_KEY  = 2'd2
    } cause_e;

endpackage

// File: rtl/pkey_perm_reg.sv
module pkey_perm_reg #(
    parameter int NUM_KEYS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2*NUM_KEYS-1:0] wr_data,
    output logic [2*NUM_KEYS-1:0] rd_data,
    output logic [NUM_KEYS-1:0]   acc_dis,
    output logic [NUM_KEYS-1:0]   wr_dis
);
    localparam int REG_W = 2 * NUM_KEYS;

    logic [REG_W-1:0] perm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            perm_q <= '0;
        end else if (wr_en) begin
            perm_q <= wr_data;
        end
    end

    assign rd_data = perm_q;

    // Even bit of each pair blocks all data access, odd bit blocks writes.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_split
        assign acc_dis[k] = perm_q[2*k];
        assign wr_dis[k]  = perm_q[2*k+1];
    end

    // R2
    wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == $past(wr_data)));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
    import pkey_pkg::*;
#(
    parameter int KEY_W = 4
) (
    input  logic                    valid,
    input  logic [KEY_W-1:0]        key,
    input  acc_e                    acc_type,
    input  logic                    page_ok,
    input  logic [(1<<KEY_W)-1:0]   acc_dis,
    input  logic [(1<<KEY_W)-1:0]   wr_dis,
    output cause_e                  cause
);
    logic ad_bit;
    logic wd_bit;

    assign ad_bit = acc_dis[key];
    assign wd_bit = wr_dis[key];

    always_comb begin
        cause = CAUSE_NONE;
        if (valid) begin
            if (!page_ok) begin
                cause = CAUSE_PAGE;
            end else begin
                unique case (acc_type)
                    ACC_LOAD:            if (ad_bit)          cause = CAUSE_KEY;
                    ACC_STORE, ACC_RSVD: if (ad_bit || wd_bit) cause = CAUSE_KEY;
                    ACC_FETCH:           cause = CAUSE_NONE;
                    default:             cause = CAUSE_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/pkey_checker.sv
module pkey_checker
    import pkey_pkg::*;
#(
    parameter bit WIDE_KEYS = 1'b0
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   sw_wr_en,
    input  logic [2*(1<<(WIDE_KEYS ? 5 : 4))-1:0]  sw_wr_data,
    output logic [2*(1<<(WIDE_KEYS ? 5 : 4))-1:0]  sw_rd_data,
    input  logic                                   req_valid,
    input  logic [(WIDE_KEYS ? 5 : 4)-1:0]         req_key,
    input  logic [1:0]                             req_type,
    input  logic                                   req_page_ok,
    output logic                                   chk_allow,
    output logic [1:0]                             chk_cause,
    output logic                                   rsp_valid,
    output logic                                   rsp_fault,
    output logic [1:0]                             rsp_cause
);
    localparam int KEY_W    = WIDE_KEYS ? 5 : 4;
    localparam int NUM_KEYS = 1 << KEY_W;

    logic [NUM_KEYS-1:0] acc_dis;
    logic [NUM_KEYS-1:0] wr_dis;
    cause_e              cause_now;

    pkey_perm_reg #(.NUM_KEYS(NUM_KEYS)) u_perm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .rd_data (sw_rd_data),
        .acc_dis (acc_dis),
        .wr_dis  (wr_dis)
    );

    pkey_decide #(.KEY_W(KEY_W)) u_decide (
        .valid    (req_valid),
        .key      (req_key),
        .acc_type (acc_e'(req_type)),
        .page_ok  (req_page_ok),
        .acc_dis  (acc_dis),
        .wr_dis   (wr_dis),
        .cause    (cause_now)
    );

    assign chk_cause = cause_now;
    assign chk_allow = (cause_now == CAUSE_NONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_fault <= req_valid && !chk_allow;
            rsp_cause <= cause_now;
        end
    end

    // R6
    page_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_page_ok) |-> (chk_cause == CAUSE_PAGE));

    // R5
    fetch_nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == ACC_FETCH) |-> (chk_cause != CAUSE_KEY));

    // R3
    load_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_page_ok && req_type == ACC_LOAD && !acc_dis[req_key]) |-> chk_allow);

    // R4
    store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_page_ok && req_type == ACC_STORE &&
         (acc_dis[req_key] || wr_dis[req_key])) |-> (chk_cause == CAUSE_KEY));

    // R9
    rsp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid) && rsp_cause == $past(chk_cause)));

    // R7
    rsp_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != CAUSE_NONE)));

endmodule

// File: tb/tb_pkey_checker.sv
module tb_pkey_checker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rq_v = 1'b0;
    logic [3:0]  rq_key = '0;
    logic [1:0]  rq_type = '0;
    logic        rq_pok = 1'b1;
    logic        allow;
    logic [1:0]  cause;
    logic        r_v, r_f;
    logic [1:0]  r_c;

    logic        wr_en_w = 1'b0;
    logic [63:0] wr_data_w = '0;
    logic [63:0] rd_data_w;
    logic        rq_v_w = 1'b0;
    logic [4:0]  rq_key_w = '0;
    logic [1:0]  rq_type_w = '0;
    logic        allow_w;
    logic [1:0]  cause_w;
    logic        r_v_w, r_f_w;
    logic [1:0]  r_c_w;

    pkey_checker dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(wr_en), .sw_wr_data(wr_data),
        .sw_rd_data(rd_data), .req_valid(rq_v), .req_key(rq_key),
        .req_type(rq_type), .req_page_ok(rq_pok), .chk_allow(allow),
        .chk_cause(cause), .rsp_valid(r_v), .rsp_fault(r_f), .rsp_cause(r_c)
    );

    pkey_checker #(.WIDE_KEYS(1'b1)) dut_w (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(wr_en_w), .sw_wr_data(wr_data_w),
        .sw_rd_data(rd_data_w), .req_valid(rq_v_w), .req_key(rq_key_w),
        .req_type(rq_type_w), .req_page_ok(1'b1), .chk_allow(allow_w),
        .chk_cause(cause_w), .rsp_valid(r_v_w), .rsp_fault(r_f_w), .rsp_cause(r_c_w)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] mdl = '0;
    bit finished = 1'b0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected cause: 0 none, 1 page, 2 key.
    function automatic logic [1:0] exp_cause(logic [3:0] k, logic [1:0] t, logic pok);
        logic ad, wd;
        ad = mdl[2*k];
        wd = mdl[2*k+1];
        if (!pok) return 2'd1;
        if (t == 2'd2) return 2'd0;
        if (t == 2'd0) return ad ? 2'd2 : 2'd0;
        return (ad || wd) ? 2'd2 : 2'd0;
    endfunction

    task automatic sw_write(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; mdl = d;
    endtask

    task automatic access(string req, logic [3:0] k, logic [1:0] t, logic pok);
        logic [1:0] e;
        @(negedge clk);
        rq_v = 1'b1; rq_key = k; rq_type = t; rq_pok = pok;
        e = exp_cause(k, t, pok);
        #1;
        chk(req, cause, e);
        chk(req, allow, e == 2'd0);
        @(posedge clk); #1;
        chk({req, " R9 valid"}, r_v, 1'b1);
        chk({req, " R9 fault"}, r_f, e != 2'd0);
        chk({req, " R9 cause"}, r_c, e);
        rq_v = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reg", rd_data, 32'h0);
        chk("R1 rsp", r_v, 1'b0);
        access("R1 store", 4'd5, 2'd1, 1'b1);
        access("R1 load", 4'd12, 2'd0, 1'b1);
    endtask

    task automatic t_bits();
        sw_write(32'h0000_0040);              // key 3 access-disable (bit 6)
        chk("R2 readback", rd_data, 32'h0000_0040);
        access("R3 load ad", 4'd3, 2'd0, 1'b1);
        access("R4 store ad", 4'd3, 2'd1, 1'b1);
        access("R3 other key", 4'd4, 2'd0, 1'b1);
        sw_write(32'h0000_0080);              // key 3 write-disable only (bit 7)
        access("R3 load wd", 4'd3, 2'd0, 1'b1);
        access("R4 store wd", 4'd3, 2'd1, 1'b1);
    endtask

    task automatic t_fetch_page();
        sw_write(32'hFFFF_FFFF);
        access("R5 fetch", 4'd3, 2'd2, 1'b1);
        access("R5 fetch k15", 4'd15, 2'd2, 1'b1);
        access("R6 load page", 4'd3, 2'd0, 1'b0);
        access("R6 store page", 4'd7, 2'd1, 1'b0);
        access("R6 fetch page", 4'd1, 2'd2, 1'b0);
        access("R7 key", 4'd2, 2'd0, 1'b1);
    endtask

    task automatic t_rsvd();
        sw_write(32'h0008_0000);              // key 9 write-disable (bit 19)
        access("R10 rsvd wd", 4'd9, 2'd3, 1'b1);
        access("R10 rsvd clear", 4'd8, 2'd3, 1'b1);
    endtask

    task automatic t_edges();
        sw_write(32'h8000_0001);              // key 0 ad, key 15 wd
        chk("R2 edge readback", rd_data, 32'h8000_0001);
        access("R2 k0 load", 4'd0, 2'd0, 1'b1);
        access("R2 k15 load", 4'd15, 2'd0, 1'b1);
        access("R2 k15 store", 4'd15, 2'd1, 1'b1);
    endtask

    task automatic t_timing();
        sw_write(32'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0010;   // key 2 access-disable (bit 4)
        rq_v = 1'b1; rq_key = 4'd2; rq_type = 2'd0; rq_pok = 1'b1;
        #1;
        chk("R8 same cycle old", cause, 2'd0);
        @(posedge clk); #1;
        chk("R8 same cycle rsp", r_c, 2'd0);
        wr_en = 1'b0; rq_v = 1'b0; mdl = 32'h0000_0010;
        access("R8 next cycle", 4'd2, 2'd0, 1'b1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        rq_v = 1'b0; rq_pok = 1'b0;
        @(posedge clk); #1;
        chk("R9 idle valid", r_v, 1'b0);
        chk("R9 idle cause", r_c, 2'd0);
        rq_pok = 1'b1;
    endtask

    task automatic t_wide();
        @(negedge clk);
        wr_en_w = 1'b1; wr_data_w = 64'h8000_0000_0000_0000;  // key 31 write-disable (bit 63)
        @(posedge clk); #1;
        wr_en_w = 1'b0;
        chk("R11 readback", rd_data_w, 64'h8000_0000_0000_0000);
        @(negedge clk);
        rq_v_w = 1'b1; rq_key_w = 5'd31; rq_type_w = 2'd1;
        #1;
        chk("R11 store k31", cause_w, 2'd2);
        @(posedge clk); #1;
        chk("R11 rsp k31", r_c_w, 2'd2);
        @(negedge clk);
        rq_type_w = 2'd0;
        #1;
        chk("R11 load k31", cause_w, 2'd0);
        rq_key_w = 5'd15; rq_type_w = 2'd1;
        #1;
        chk("R11 store k15", cause_w, 2'd0);
        rq_v_w = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_bits();
        t_fetch_page();
        t_rsvd();
        t_edges();
        t_timing();
        t_idle();
        t_wide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule